// File: doc/BRIEF.md
# Bit-Alias Access Bridge

This bridge sits between one bus master and a memory organised in 32-bit words. A wide alias window gives every bit of a smaller backing region its own word-aligned address. A word load from one of those addresses returns that single memory bit in bit 0. A word store to it sets or clears that one bit through a locked read-modify-write. Every address outside the alias window, including the backing region itself, is forwarded to the memory without change. The master and memory sides are both valid/ready request/response ports, and only one request is in flight at any time.

The address mapping works as follows. Take the byte offset of an address inside the alias window. Bits [6:2] of that offset give the bit number. The bits above bit 6 give the index of the backing word. So the 32 bits of one backing word occupy 32 consecutive alias words, 4 byte addresses apart, and the next backing word's bits follow at offset 0x80.

The controller is a state machine with ten named states. `ST_IDLE` is the only state in which the master may hand over a request. From there the first transition depends on the decoded kind of request:

- A forwarded access takes `ST_IDLE -> ST_FWD_REQ -> ST_FWD_WAIT -> ST_REPLY`.
- An alias read takes `ST_IDLE -> ST_BIT_REQ -> ST_BIT_WAIT -> ST_REPLY`.
- An alias write takes `ST_IDLE -> ST_MOD_REQ -> ST_MOD_WAIT -> ST_PUT_REQ -> ST_PUT_WAIT -> ST_REPLY`. If the memory reports an error in `ST_MOD_WAIT`, it goes straight to `ST_REPLY` and skips the write-back.
- A misaligned alias access goes `ST_IDLE -> ST_REPLY` directly.

`ST_REPLY` returns to `ST_IDLE` once the master accepts the response. Each `*_REQ` state moves to its `*_WAIT` state on the memory request handshake. Each `*_WAIT` state moves on when the memory response arrives.

Top module: `bitalias_bridge`

## Requirements
- R1: A request whose address lies outside the alias window [0x22000000, 0x24000000) is forwarded with the same address, write flag and write data and with the lock low. The memory's read data and error flag are returned unchanged. This also holds for addresses that are not word aligned.
- R2: An alias address A maps to the backing word address 0x20000000 + ((A - 0x22000000) >> 7) * 4 and to bit number ((A - 0x22000000) >> 2) mod 32. For example, 0x22000004 maps to bit 1 of 0x20000000, and 0x22000080 maps to bit 0 of 0x20000004.
- R3: An alias read issues a single memory read of the mapped word with the lock low. It returns that word's selected bit in response bit 0, with bits 31:1 zero, and it passes on the memory's error flag.
- R4: An alias write reads the mapped word and then writes it back with only the selected bit replaced by write-data bit 0. Write-data bits 31:1 have no effect. It responds OKAY with data 0 once the write-back response arrives.
- R5: The lock output is high on both memory requests of an alias write and stays high until the write-back response. It is low in every other state.
- R6: An alias access whose address bits [1:0] are not 00 produces an error response with data 0 and issues no memory request.
- R7: The master request ready is high only in `ST_IDLE`. While it is high, no memory request and no master response are pending.
- R8: If the read phase of an alias write returns an error, the bridge answers with an error and issues no write-back.
- R9: A memory request that has not been accepted, and a master response that has not been accepted, keep their valid and payload stable.
- R10: The top of the alias window, 0x23FFFFFC, maps to bit 31 of 0x200FFFFC. The addresses 0x24000000 and 0x21FFFFFC are forwarded as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Bridge can take a request |
| m_req_addr | input | 32 | Master byte address |
| m_req_write | input | 1 | 1 = write, 0 = read |
| m_req_wdata | input | 32 | Master write data |
| m_rsp_valid | output | 1 | Response to master valid |
| m_rsp_ready | input | 1 | Master accepts response |
| m_rsp_rdata | output | 32 | Response read data |
| m_rsp_err | output | 1 | Response error flag |
| s_req_valid | output | 1 | Memory request valid |
| s_req_ready | input | 1 | Memory accepts request |
| s_req_addr | output | 32 | Memory byte address |
| s_req_write | output | 1 | Memory write flag |
| s_req_wdata | output | 32 | Memory write data |
| s_req_lock | output | 1 | Memory port locked for read-modify-write |
| s_rsp_valid | input | 1 | Memory response valid |
| s_rsp_ready | output | 1 | Bridge accepts memory response |
| s_rsp_rdata | input | 32 | Memory read data |
| s_rsp_err | input | 1 | Memory error flag |

## Verification
The bench builds the bridge with its default parameters: a 1 MiB backing region at 0x20000000 and a 32 MiB alias window at 0x22000000. Because the window keeps its full default size, the mapping can be checked at both of its ends: the first bits of the first backing word, the second word, the last alias word, and the addresses just outside the window on either side. The bench's memory model stalls on its request ready and delays its responses using a pseudo-random pattern, and the master's response ready also stalls at times. This exercises every wait state, both hold rules and the lock window. One backing word is marked to return errors, which reaches both the alias-read error path and the aborted read-modify-write.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FWD_REQ,
        ST_FWD_WAIT,
        ST_BIT_REQ,
        ST_BIT_WAIT,
        ST_MOD_REQ,
        ST_MOD_WAIT,
        ST_PUT_REQ,
        ST_PUT_WAIT,
        ST_REPLY
    } bb_state_e;

    typedef enum logic [1:0] {
        K_PASS,
        K_BIT_READ,
        K_BIT_WRITE,
        K_MISALIGNED
    } bb_kind_e;

endpackage

// File: rtl/bb_addr_decode.sv
module bb_addr_decode
    import bitalias_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned BACK_LOG2  = 20,
    parameter logic [ADDR_W-1:0] BACK_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      write,
    output bb_kind_e                  kind,
    output logic [ADDR_W-1:0]         word_addr,
    output logic [$clog2(DATA_W)-1:0] bit_idx
);
    localparam int unsigned BIT_W      = $clog2(DATA_W);
    localparam int unsigned BYTE_LSB   = $clog2(DATA_W / 8);
    localparam int unsigned ALIAS_LOG2 = BACK_LOG2 + BIT_W;
    localparam int unsigned WIDX_W     = BACK_LOG2 - BYTE_LSB;

    logic              in_alias;
    logic              misal;
    logic [WIDX_W-1:0] widx;

    always_comb begin
        in_alias  = (addr[ADDR_W-1:ALIAS_LOG2] == ALIAS_BASE[ADDR_W-1:ALIAS_LOG2]);
        misal     = |addr[BYTE_LSB-1:0];
        bit_idx   = addr[BYTE_LSB +: BIT_W];
        widx      = addr[BYTE_LSB + BIT_W +: WIDX_W];
        word_addr = BACK_BASE | ({{(ADDR_W - WIDX_W){1'b0}}, widx} << BYTE_LSB);
        if (!in_alias) begin
            kind = K_PASS;
        end else if (misal) begin
            kind = K_MISALIGNED;
        end else if (write) begin
            kind = K_BIT_WRITE;
        end else begin
            kind = K_BIT_READ;
        end
    end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]         word_in,
    input  logic [$clog2(DATA_W)-1:0] bit_idx,
    input  logic                      bit_val,
    output logic                      bit_out,
    output logic [DATA_W-1:0]         merged
);
    always_comb begin
        bit_out          = word_in[bit_idx];
        merged           = word_in;
        merged[bit_idx]  = bit_val;
    end

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
    import bitalias_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      m_req_valid,
    output logic                      m_req_ready,
    input  logic [ADDR_W-1:0]         in_addr,
    input  logic                      in_write,
    input  logic [DATA_W-1:0]         in_wdata,
    input  bb_kind_e                  in_kind,
    input  logic [ADDR_W-1:0]         in_word_addr,
    input  logic [$clog2(DATA_W)-1:0] in_bit_idx,
    output logic                      m_rsp_valid,
    input  logic                      m_rsp_ready,
    output logic [DATA_W-1:0]         m_rsp_rdata,
    output logic                      m_rsp_err,
    output logic                      s_req_valid,
    input  logic                      s_req_ready,
    output logic [ADDR_W-1:0]         s_req_addr,
    output logic                      s_req_write,
    output logic [DATA_W-1:0]         s_req_wdata,
    output logic                      s_req_lock,
    input  logic                      s_rsp_valid,
    output logic                      s_rsp_ready,
    input  logic                      s_rsp_err,
    input  logic                      sel_bit,
    input  logic [DATA_W-1:0]         merged_word,
    output logic [$clog2(DATA_W)-1:0] cur_bit_idx,
    output logic                      cur_bit_val,
    output bb_kind_e                  cur_kind,
    output bb_state_e                 state_o
);
    localparam int unsigned BIT_W = $clog2(DATA_W);

    bb_state_e         state, state_nx;
    logic [ADDR_W-1:0] cap_addr, cap_word;
    logic              cap_write;
    logic [DATA_W-1:0] cap_wdata, put_word, rsp_data;
    logic [BIT_W-1:0]  cap_bit;
    bb_kind_e          cap_kind;
    logic              rsp_err;
    logic              take, mem_hs, back_hs;

    assign take    = m_req_valid && m_req_ready;
    assign mem_hs  = s_req_valid && s_req_ready;
    assign back_hs = s_rsp_valid && s_rsp_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (m_req_valid) begin
                    unique case (in_kind)
                        K_PASS:       state_nx = ST_FWD_REQ;
                        K_BIT_READ:   state_nx = ST_BIT_REQ;
                        K_BIT_WRITE:  state_nx = ST_MOD_REQ;
                        K_MISALIGNED: state_nx = ST_REPLY;
                        default:      state_nx = ST_REPLY;
                    endcase
                end
            end
            ST_FWD_REQ:  if (s_req_ready) state_nx = ST_FWD_WAIT;
            ST_FWD_WAIT: if (s_rsp_valid) state_nx = ST_REPLY;
            ST_BIT_REQ:  if (s_req_ready) state_nx = ST_BIT_WAIT;
            ST_BIT_WAIT: if (s_rsp_valid) state_nx = ST_REPLY;
            ST_MOD_REQ:  if (s_req_ready) state_nx = ST_MOD_WAIT;
            ST_MOD_WAIT: if (s_rsp_valid) state_nx = s_rsp_err ? ST_REPLY : ST_PUT_REQ;
            ST_PUT_REQ:  if (s_req_ready) state_nx = ST_PUT_WAIT;
            ST_PUT_WAIT: if (s_rsp_valid) state_nx = ST_REPLY;
            ST_REPLY:    if (m_rsp_ready) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        m_req_ready = 1'b0;
        m_rsp_valid = 1'b0;
        s_req_valid = 1'b0;
        s_req_addr  = cap_word;
        s_req_write = 1'b0;
        s_req_wdata = '0;
        s_req_lock  = 1'b0;
        s_rsp_ready = 1'b0;
        unique case (state)
            ST_IDLE:     m_req_ready = 1'b1;
            ST_FWD_REQ: begin
                s_req_valid = 1'b1;
                s_req_addr  = cap_addr;
                s_req_write = cap_write;
                s_req_wdata = cap_wdata;
            end
            ST_FWD_WAIT: s_rsp_ready = 1'b1;
            ST_BIT_REQ:  s_req_valid = 1'b1;
            ST_BIT_WAIT: s_rsp_ready = 1'b1;
            ST_MOD_REQ: begin
                s_req_valid = 1'b1;
                s_req_lock  = 1'b1;
            end
            ST_MOD_WAIT: begin
                s_rsp_ready = 1'b1;
                s_req_lock  = 1'b1;
            end
            ST_PUT_REQ: begin
                s_req_valid = 1'b1;
                s_req_write = 1'b1;
                s_req_wdata = put_word;
                s_req_lock  = 1'b1;
            end
            ST_PUT_WAIT: begin
                s_rsp_ready = 1'b1;
                s_req_lock  = 1'b1;
            end
            ST_REPLY:    m_rsp_valid = 1'b1;
            default: ;
        endcase
    end

    // Captured request and response payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_word  <= '0;
            cap_write <= 1'b0;
            cap_wdata <= '0;
            cap_bit   <= '0;
            cap_kind  <= K_PASS;
            put_word  <= '0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            if (take) begin
                cap_addr  <= in_addr;
                cap_word  <= in_word_addr;
                cap_write <= in_write;
                cap_wdata <= in_wdata;
                cap_bit   <= in_bit_idx;
                cap_kind  <= in_kind;
                rsp_data  <= '0;
                rsp_err   <= (in_kind == K_MISALIGNED);
            end
            if (back_hs) begin
                unique case (state)
                    ST_FWD_WAIT: begin
                        rsp_data <= merged_word;
                        rsp_err  <= s_rsp_err;
                    end
                    ST_BIT_WAIT: begin
                        rsp_data <= {{(DATA_W-1){1'b0}}, sel_bit};
                        rsp_err  <= s_rsp_err;
                    end
                    ST_MOD_WAIT: begin
                        put_word <= merged_word;
                        rsp_data <= '0;
                        rsp_err  <= s_rsp_err;
                    end
                    ST_PUT_WAIT: begin
                        rsp_data <= '0;
                        rsp_err  <= s_rsp_err;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign m_rsp_rdata = rsp_data;
    assign m_rsp_err   = rsp_err;
    assign cur_bit_idx = cap_bit;
    assign cur_bit_val = cap_wdata[0];
    assign cur_kind    = cap_kind;
    assign state_o     = state;

    // R5
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_req_lock) |-> $past(back_hs));

    // R8
    no_putback_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MOD_WAIT && back_hs && s_rsp_err) |=> !s_req_valid);

    // R3
    bit_read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_WAIT && back_hs) |=> !s_req_valid);

    logic unused_ok;
    assign unused_ok = mem_hs;

endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
    import bitalias_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned BACK_LOG2  = 20,
    parameter logic [ADDR_W-1:0] BACK_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req_valid,
    output logic              m_req_ready,
    input  logic [ADDR_W-1:0] m_req_addr,
    input  logic              m_req_write,
    input  logic [DATA_W-1:0] m_req_wdata,
    output logic              m_rsp_valid,
    input  logic              m_rsp_ready,
    output logic [DATA_W-1:0] m_rsp_rdata,
    output logic              m_rsp_err,
    output logic              s_req_valid,
    input  logic              s_req_ready,
    output logic [ADDR_W-1:0] s_req_addr,
    output logic              s_req_write,
    output logic [DATA_W-1:0] s_req_wdata,
    output logic              s_req_lock,
    input  logic              s_rsp_valid,
    output logic              s_rsp_ready,
    input  logic [DATA_W-1:0] s_rsp_rdata,
    input  logic              s_rsp_err
);
    localparam int unsigned BIT_W = $clog2(DATA_W);

    bb_kind_e          dec_kind, cur_kind;
    bb_state_e         state;
    logic [ADDR_W-1:0] dec_word;
    logic [BIT_W-1:0]  dec_bit, cur_bit;
    logic              cur_val, sel_bit;
    logic [DATA_W-1:0] merged, merge_src;

    bb_addr_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .BACK_LOG2  (BACK_LOG2),
        .BACK_BASE  (BACK_BASE),
        .ALIAS_BASE (ALIAS_BASE)
    ) u_decode (
        .addr      (m_req_addr),
        .write     (m_req_write),
        .kind      (dec_kind),
        .word_addr (dec_word),
        .bit_idx   (dec_bit)
    );

    // Forwarded reads pass the word untouched: merge writes back its own bit.
    logic pass_mode;
    assign pass_mode = (state == ST_FWD_WAIT);
    assign merge_src = s_rsp_rdata;

    logic merge_val;
    assign merge_val = pass_mode ? s_rsp_rdata[cur_bit] : cur_val;

    bb_bit_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .word_in (merge_src),
        .bit_idx (cur_bit),
        .bit_val (merge_val),
        .bit_out (sel_bit),
        .merged  (merged)
    );

    bb_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .m_req_valid  (m_req_valid),
        .m_req_ready  (m_req_ready),
        .in_addr      (m_req_addr),
        .in_write     (m_req_write),
        .in_wdata     (m_req_wdata),
        .in_kind      (dec_kind),
        .in_word_addr (dec_word),
        .in_bit_idx   (dec_bit),
        .m_rsp_valid  (m_rsp_valid),
        .m_rsp_ready  (m_rsp_ready),
        .m_rsp_rdata  (m_rsp_rdata),
        .m_rsp_err    (m_rsp_err),
        .s_req_valid  (s_req_valid),
        .s_req_ready  (s_req_ready),
        .s_req_addr   (s_req_addr),
        .s_req_write  (s_req_write),
        .s_req_wdata  (s_req_wdata),
        .s_req_lock   (s_req_lock),
        .s_rsp_valid  (s_rsp_valid),
        .s_rsp_ready  (s_rsp_ready),
        .s_rsp_err    (s_rsp_err),
        .sel_bit      (sel_bit),
        .merged_word  (merged),
        .cur_bit_idx  (cur_bit),
        .cur_bit_val  (cur_val),
        .cur_kind     (cur_kind),
        .state_o      (state)
    );

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req_valid && !s_req_ready) |=> (s_req_valid && $stable(s_req_addr)
            && $stable(s_req_write) && $stable(s_req_wdata) && $stable(s_req_lock)));

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rsp_valid && !m_rsp_ready) |=> (m_rsp_valid && $stable(m_rsp_rdata)
            && $stable(m_rsp_err)));

    // R7
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req_ready |-> (!s_req_valid && !m_rsp_valid && !s_req_lock));

    // R3
    alias_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rsp_valid && cur_kind == K_BIT_READ) |-> (m_rsp_rdata[DATA_W-1:1] == '0));

    // R6
    misaligned_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_kind == K_MISALIGNED && !m_req_ready) |-> (!s_req_valid && m_rsp_valid && m_rsp_err));

    // R4
    one_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MOD_WAIT && s_rsp_valid) |-> ($countones(merged ^ s_rsp_rdata) <= 1));

endmodule

// File: tb/bitalias_bridge_bench.sv
`timescale 1ns/100ps
module bitalias_bridge_bench;

    localparam logic [31:0] BAD_WORD = 32'h2000_0F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req_valid = 1'b0;
    logic        m_req_ready;
    logic [31:0] m_req_addr = '0;
    logic        m_req_write = 1'b0;
    logic [31:0] m_req_wdata = '0;
    logic        m_rsp_valid;
    logic        m_rsp_ready = 1'b0;
    logic [31:0] m_rsp_rdata;
    logic        m_rsp_err;
    logic        s_req_valid;
    logic        s_req_ready = 1'b0;
    logic [31:0] s_req_addr;
    logic        s_req_write;
    logic [31:0] s_req_wdata;
    logic        s_req_lock;
    logic        s_rsp_valid = 1'b0;
    logic        s_rsp_ready;
    logic [31:0] s_rsp_rdata = '0;
    logic        s_rsp_err = 1'b0;

    int checks = 0;
    int errors = 0;
    int rsp_count = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bitalias_bridge u_bitalias_bridge (
        .clk (clk), .rst_n (rst_n),
        .m_req_valid (m_req_valid), .m_req_ready (m_req_ready),
        .m_req_addr (m_req_addr), .m_req_write (m_req_write), .m_req_wdata (m_req_wdata),
        .m_rsp_valid (m_rsp_valid), .m_rsp_ready (m_rsp_ready),
        .m_rsp_rdata (m_rsp_rdata), .m_rsp_err (m_rsp_err),
        .s_req_valid (s_req_valid), .s_req_ready (s_req_ready),
        .s_req_addr (s_req_addr), .s_req_write (s_req_write),
        .s_req_wdata (s_req_wdata), .s_req_lock (s_req_lock),
        .s_rsp_valid (s_rsp_valid), .s_rsp_ready (s_rsp_ready),
        .s_rsp_rdata (s_rsp_rdata), .s_rsp_err (s_rsp_err)
    );

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return a ^ 32'h5A3C_96E1;
    endfunction

    // Memory model storage and independent shadow of expected contents
    logic [31:0] mem    [logic [31:0]];
    logic [31:0] shadow [logic [31:0]];

    function automatic logic [31:0] shadow_rd(input logic [31:0] a);
        return shadow.exists(a) ? shadow[a] : init_word(a);
    endfunction

    // Scoreboard queues
    logic [31:0] eo_addr[$];
    logic        eo_write[$];
    logic [31:0] eo_wdata[$];
    logic        eo_lock[$];
    string       eo_tag[$];
    logic [31:0] er_data[$];
    logic        er_err[$];
    logic        er_chk[$];
    string       er_tag[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Memory model with pseudo-random stalls and latency
    logic [7:0]  lf;
    logic        mm_busy;
    logic [1:0]  mm_lat;
    logic [31:0] mm_addr;
    logic        mm_wr;
    always @(posedge clk) begin
        if (!rst_n) begin
            lf          <= 8'hA5;
            mm_busy     <= 1'b0;
            mm_lat      <= '0;
            mm_addr     <= '0;
            mm_wr       <= 1'b0;
            s_req_ready <= 1'b0;
            s_rsp_valid <= 1'b0;
            m_rsp_ready <= 1'b0;
        end else begin
            lf          <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            m_rsp_ready <= lf[6] | lf[1];
            if (s_rsp_valid && s_rsp_ready) s_rsp_valid <= 1'b0;
            if (mm_busy) begin
                if (mm_lat == 2'd0) begin
                    s_rsp_valid <= 1'b1;
                    s_rsp_rdata <= mm_wr ? 32'h0 :
                                   (mem.exists(mm_addr) ? mem[mm_addr] : init_word(mm_addr));
                    s_rsp_err   <= (mm_addr == BAD_WORD);
                    mm_busy     <= 1'b0;
                end else begin
                    mm_lat <= mm_lat - 2'd1;
                end
            end else if (s_req_valid && s_req_ready) begin
                mm_busy     <= 1'b1;
                mm_lat      <= lf[1:0];
                mm_addr     <= s_req_addr;
                mm_wr       <= s_req_write;
                s_req_ready <= 1'b0;
                if (s_req_write && s_req_addr != BAD_WORD) mem[s_req_addr] = s_req_wdata;
            end else begin
                s_req_ready <= !s_rsp_valid && lf[2];
            end
        end
    end

    // Monitor: memory requests and master responses
    always @(negedge clk) begin
        if (rst_n && s_req_valid && s_req_ready) begin
            if (eo_addr.size() == 0) begin
                check(1'b0, "R6", "unexpected memory request addr", s_req_addr, 32'h0);
            end else begin
                automatic logic [31:0] xa = eo_addr.pop_front();
                automatic logic        xw = eo_write.pop_front();
                automatic logic [31:0] xd = eo_wdata.pop_front();
                automatic logic        xl = eo_lock.pop_front();
                automatic string       xt = eo_tag.pop_front();
                check(s_req_addr == xa, xt, "memory addr", s_req_addr, xa);
                check(s_req_write == xw, xt, "memory write flag", 32'(s_req_write), 32'(xw));
                if (xw) check(s_req_wdata == xd, xt, "memory wdata", s_req_wdata, xd);
                check(s_req_lock == xl, "R5", "lock", 32'(s_req_lock), 32'(xl));
            end
        end
        if (rst_n && m_rsp_valid && m_rsp_ready) begin
            if (er_err.size() == 0) begin
                check(1'b0, "R7", "unexpected response", m_rsp_rdata, 32'h0);
            end else begin
                automatic logic [31:0] xd = er_data.pop_front();
                automatic logic        xe = er_err.pop_front();
                automatic logic        xc = er_chk.pop_front();
                automatic string       xt = er_tag.pop_front();
                check(m_rsp_err == xe, xt, "response err", 32'(m_rsp_err), 32'(xe));
                if (xc) check(m_rsp_rdata == xd, xt, "response data", m_rsp_rdata, xd);
            end
            rsp_count++;
        end
    end

    // Driver: pushes expectations, then issues the request
    task automatic do_op(input logic [31:0] a, input logic w, input logic [31:0] d,
                         input string tag);
        int n0;
        bit in_alias = (a >= 32'h2200_0000) && (a < 32'h2400_0000);
        if (in_alias && a[1:0] != 2'b00) begin
            er_data.push_back(32'h0); er_err.push_back(1'b1);
            er_chk.push_back(1'b1); er_tag.push_back(tag);
        end else if (in_alias) begin
            automatic logic [31:0] off = a - 32'h2200_0000;
            automatic logic [31:0] wa  = 32'h2000_0000 + (off / 128) * 4;
            automatic int          b   = int'((off / 4) % 32);
            automatic logic [31:0] cur = shadow_rd(wa);
            eo_addr.push_back(wa); eo_write.push_back(1'b0); eo_wdata.push_back(32'h0);
            eo_lock.push_back(w); eo_tag.push_back(tag);
            if (wa == BAD_WORD) begin
                er_data.push_back(32'h0); er_err.push_back(1'b1);
                er_chk.push_back(w); er_tag.push_back(tag);
            end else if (!w) begin
                er_data.push_back({31'h0, cur[b]}); er_err.push_back(1'b0);
                er_chk.push_back(1'b1); er_tag.push_back(tag);
            end else begin
                automatic logic [31:0] nw = cur;
                nw[b] = d[0];
                shadow[wa] = nw;
                eo_addr.push_back(wa); eo_write.push_back(1'b1); eo_wdata.push_back(nw);
                eo_lock.push_back(1'b1); eo_tag.push_back(tag);
                er_data.push_back(32'h0); er_err.push_back(1'b0);
                er_chk.push_back(1'b1); er_tag.push_back(tag);
            end
        end else begin
            eo_addr.push_back(a); eo_write.push_back(w); eo_wdata.push_back(d);
            eo_lock.push_back(1'b0); eo_tag.push_back(tag);
            er_data.push_back(w ? 32'h0 : shadow_rd(a));
            er_err.push_back(a == BAD_WORD);
            er_chk.push_back(1'b1); er_tag.push_back(tag);
            if (w) shadow[a] = d;
        end
        n0 = rsp_count;
        @(negedge clk);
        m_req_addr  = a;
        m_req_write = w;
        m_req_wdata = d;
        m_req_valid = 1'b1;
        while (!m_req_ready) @(negedge clk);
        @(negedge clk);
        m_req_valid = 1'b0;
        check(!m_req_ready, "R7", "ready while busy", 32'(m_req_ready), 32'h0);
        while (rsp_count == n0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R7, R5)
        check(m_req_ready == 1'b1, "R7", "reset ready", 32'(m_req_ready), 32'h1);
        check(m_rsp_valid == 1'b0, "R7", "reset rsp valid", 32'(m_rsp_valid), 32'h0);
        check(s_req_valid == 1'b0, "R7", "reset mem valid", 32'(s_req_valid), 32'h0);
        check(s_req_lock == 1'b0, "R5", "reset lock", 32'(s_req_lock), 32'h0);

        // R1: forwarded accesses to the backing region
        do_op(32'h2000_0000, 1'b1, 32'hA5A5_0F0F, "R1");
        do_op(32'h2000_0000, 1'b0, 32'h0, "R1");
        do_op(32'h2000_0001, 1'b0, 32'h0, "R1");
        // R2/R3: alias reads of bits of the first word
        do_op(32'h2200_0000, 1'b0, 32'h0, "R2");
        do_op(32'h2200_0004, 1'b0, 32'h0, "R2");
        do_op(32'h2200_001C, 1'b0, 32'h0, "R3");
        do_op(32'h2200_007C, 1'b0, 32'h0, "R3");
        do_op(32'h2200_0008, 1'b0, 32'h0, "R3");
        // R4: set and clear with junk in upper write-data bits
        do_op(32'h2200_0010, 1'b1, 32'h0000_0001, "R4");
        do_op(32'h2200_0000, 1'b1, 32'hFFFF_FFFE, "R4");
        do_op(32'h2200_0044, 1'b1, 32'hDEAD_BEEF, "R4");
        do_op(32'h2000_0000, 1'b0, 32'h0, "R4");
        // R2: second backing word
        do_op(32'h2200_008C, 1'b1, 32'h1, "R2");
        do_op(32'h2200_008C, 1'b0, 32'h0, "R2");
        do_op(32'h2000_0004, 1'b0, 32'h0, "R2");
        // R10: window edges
        do_op(32'h23FF_FFFC, 1'b1, 32'h0, "R10");
        do_op(32'h23FF_FFFC, 1'b0, 32'h0, "R10");
        do_op(32'h2000_0000 + 32'h000F_FFFC, 1'b0, 32'h0, "R10");
        do_op(32'h2400_0000, 1'b1, 32'h1234_5678, "R10");
        do_op(32'h2400_0000, 1'b0, 32'h0, "R10");
        do_op(32'h21FF_FFFC, 1'b0, 32'h0, "R10");
        // R6: misaligned alias accesses, then a readback proving no change
        do_op(32'h2200_0002, 1'b0, 32'h0, "R6");
        do_op(32'h2200_0005, 1'b1, 32'h1, "R6");
        do_op(32'h2000_0000, 1'b0, 32'h0, "R6");
        // R8 / R3: error from the backing memory
        do_op(32'h2201_E000 + 32'h0C, 1'b1, 32'h1, "R8");
        do_op(32'h2201_E000 + 32'h10, 1'b0, 32'h0, "R3");
        do_op(BAD_WORD, 1'b0, 32'h0, "R1");
        // Back-to-back mixed pattern under stalls (R9)
        for (int i = 0; i < 8; i++) begin
            do_op(32'h2200_0100 + 32'(i) * 4, 1'b1, 32'(i & 1), "R9");
        end
        do_op(32'h2000_0008, 1'b0, 32'h0, "R9");

        repeat (10) @(negedge clk);
        check(eo_addr.size() == 0, "R8", "leftover memory ops", 32'(eo_addr.size()), 32'h0);
        check(er_err.size() == 0, "R7", "leftover responses", 32'(er_err.size()), 32'h0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule